// File: doc/BRIEF.md
# Audio DC-Offset Removal Filter with Offset Hold

This block removes the DC component from a stream of 24-bit two's-complement audio samples that leaves a decimation filter. Left and right samples arrive interleaved on one bus, each marked by a valid strobe and a channel bit. Each channel has its own leaky accumulator that follows the slowly moving DC level of that channel. The integer part of that estimate is taken away from every sample. The shift amount `K` sets the corner frequency: `K` = 13 puts it near 1 Hz at a 48 kHz rate, and the corner moves in proportion to the sample rate.

A hold input stops both estimates from learning, while the stored values are still subtracted from later samples. To calibrate the system offset, the filter runs unheld until the estimate settles and then the hold is asserted. After that, the offset measured at that moment is taken away from all later audio without any further drift. Results are clipped to the 24-bit signed range, so they never wrap.

Top module: `dc_offset_hpf`

## Requirements
- R1: A synchronous active-high reset clears both channel estimates to zero, so the first sample on each channel after reset comes out unchanged, and `out_valid` is low while in reset.
- R2: Each sample accepted with `in_valid` high produces exactly one result, with `out_valid` high on the next clock and `out_right` equal to the accepted channel bit. A cycle with `in_valid` low gives `out_valid` low on the next clock and leaves both estimates unchanged, whatever `in_data` holds.
- R3: The result equals clip(x − E), where x is the sample and E is floor(A / 2^K) for the channel's accumulator A as it was before that sample.
- R4: While hold is low, each accepted sample updates its channel's accumulator as A ← A + floor((x·2^K − A) / 2^K).
- R5: Channel bit 0 selects left and 1 selects right. A sample on one channel never changes the other channel's estimate.
- R6: While `hold` is high, accepted samples leave the accumulators unchanged, and the held estimate is still subtracted from every result.
- R7: Results outside the range −8388608 to 8388607 are clipped to the nearest limit and are never wrapped.
- R8: A constant input held on a channel drives that channel's results toward zero, reaching a magnitude of at most 2 once the estimate has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_right | input | 1 | Channel of the incoming sample (0 left, 1 right) |
| in_data | input | 24 | Incoming two's-complement sample |
| hold | input | 1 | Freezes both offset estimates when high |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_right | output | 1 | Channel of the result |
| out_data | output | 24 | Offset-corrected, clipped sample |

## Verification
Clipping is the hardest case to reach from the ports. An output can only pass the 24-bit limits after one channel's estimate has been pushed close to one extreme and a sample of the opposite extreme then arrives. Random samples never build up such an estimate. The bench therefore runs the block with a small shift, feeds each channel a long run of full-scale samples of one sign until its estimate settles at that rail, and then sends the opposite full-scale value. It also interleaves random samples, hold toggles and idle cycles, so that channel independence and the unchanged state after idle cycles are checked on the outputs.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int DATA_W = 24;

    typedef logic signed [DATA_W-1:0] sample_t;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic    valid;
        chan_e   chan;
        sample_t data;
    } beat_t;

    localparam sample_t S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam sample_t S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    // Reduce a one-bit-wider signed value to the sample range.
    function automatic sample_t clip_wide(input logic signed [DATA_W:0] v);
        if (v[DATA_W] != v[DATA_W-1]) begin
            return v[DATA_W] ? S_MIN : S_MAX;
        end
        return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/dcb_tracker.sv
module dcb_tracker
    import dcb_pkg::*;
#(
    parameter int K = 13
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    upd,
    input  logic    hold,
    input  sample_t x,
    output sample_t est
);
    localparam int ACC_W = DATA_W + K + 1;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] diff;
    logic signed [ACC_W-1:0] step;
    logic signed [ACC_W-1:0] acc_nxt;

    always_comb begin
        x_ext   = {x[DATA_W-1], x, {K{1'b0}}};
        diff    = x_ext - acc;
        step    = diff >>> K;
        acc_nxt = acc + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (upd && !hold) begin
            acc <= acc_nxt;
        end
    end

    // Integer part of the estimate (floor of acc / 2^K).
    assign est = acc[K +: DATA_W];

    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> acc == '0);

    p_idle_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(acc));

    p_toward_input_r4: assert property (@(posedge clk) disable iff (rst)
        (upd && !hold && x_ext >= acc) |=> acc >= $past(acc));

    p_below_input_r4: assert property (@(posedge clk) disable iff (rst)
        (upd && !hold && x_ext <= acc) |=> acc <= $past(acc));

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (upd && hold) |=> $stable(acc));

endmodule

// File: rtl/dcb_remove.sv
module dcb_remove
    import dcb_pkg::*;
(
    input  sample_t x,
    input  sample_t est,
    output sample_t y
);
    logic signed [DATA_W:0] wide;

    always_comb begin
        wide = $signed({x[DATA_W-1], x}) - $signed({est[DATA_W-1], est});
        y    = clip_wide(wide);
    end

endmodule

// File: rtl/dc_offset_hpf.sv
module dc_offset_hpf
    import dcb_pkg::*;
#(
    parameter int K = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_right,
    input  logic [DATA_W-1:0] in_data,
    input  logic              hold,
    output logic              out_valid,
    output logic              out_right,
    output logic [DATA_W-1:0] out_data
);
    localparam int N_CH = 2;

    sample_t est_arr [N_CH];
    sample_t est_sel;
    sample_t corrected;
    beat_t   res_q;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dcb_tracker #(.K(K)) u_trk (
            .clk  (clk),
            .rst  (rst),
            .upd  (in_valid && (in_right == g[0])),
            .hold (hold),
            .x    (sample_t'(in_data)),
            .est  (est_arr[g])
        );
    end

    assign est_sel = in_right ? est_arr[1] : est_arr[0];

    dcb_remove u_rem (
        .x   (sample_t'(in_data)),
        .est (est_sel),
        .y   (corrected)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid;
            if (in_valid) begin
                res_q.chan <= chan_e'(in_right);
                res_q.data <= corrected;
            end
        end
    end

    assign out_valid = res_q.valid;
    assign out_right = res_q.chan;
    assign out_data  = res_q.data;

    p_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_right == $past(in_right)));

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_left_only_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_right) |=> $stable(est_arr[1]));

    p_right_only_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_right) |=> $stable(est_arr[0]));

    p_no_wrap_pos_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_data[DATA_W-1] && est_sel[DATA_W-1]) |=> !out_data[DATA_W-1]);

    p_no_wrap_neg_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data[DATA_W-1] && !est_sel[DATA_W-1]) |=> out_data[DATA_W-1]);

endmodule

// File: tb/dc_offset_hpf_tb.sv
`timescale 1ns/1ps
module dc_offset_hpf_tb;
    localparam int  KS   = 6;
    localparam longint SMAXL = 64'sd8388607;
    localparam longint SMINL = -64'sd8388608;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_right = 1'b0;
    logic [23:0] in_data = '0;
    logic        hold = 1'b0;
    logic        out_valid;
    logic        out_right;
    logic [23:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    longint acc_m [2];

    always #2 clk = ~clk;

    dc_offset_hpf #(.K(KS)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_right  (in_right),
        .in_data   (in_data),
        .hold      (hold),
        .out_valid (out_valid),
        .out_right (out_right),
        .out_data  (out_data)
    );

    function automatic longint clip_m(input longint v);
        if (v > SMAXL) return SMAXL;
        if (v < SMINL) return SMINL;
        return v;
    endfunction

    function automatic longint est_m(input int ch);
        return acc_m[ch] >>> KS;
    endfunction

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint predict(input int ch, input longint x);
        return clip_m(x - est_m(ch));
    endfunction

    function automatic void advance(input int ch, input longint x, input logic frz);
        if (!frz) acc_m[ch] = acc_m[ch] + (((x <<< KS) - acc_m[ch]) >>> KS);
    endfunction

    // Send one sample, check its result; returns the actual output.
    task automatic send(input int ch, input longint x, input logic frz,
                        input string req, output longint got);
        longint exp;
        @(negedge clk);
        in_valid = 1'b1;
        in_right = ch[0];
        in_data  = x[23:0];
        hold     = frz;
        exp = predict(ch, x);
        advance(ch, x, frz);
        @(negedge clk);
        in_valid = 1'b0;
        got = sx(out_data);
        chk({req, " valid"}, longint'(out_valid), 1);
        chk({req, " chan"},  longint'(out_right), longint'(ch));
        chk(req, got, exp);
    endtask

    task automatic idle(input logic [23:0] junk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = junk;
        in_right = junk[0];
        hold     = junk[1];
        @(negedge clk);
        chk("R2 idle no output", longint'(out_valid), 0);
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        longint got;
        longint held;
        void'($urandom(32'd20240611));
        acc_m[0] = 0;
        acc_m[1] = 0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", longint'(out_valid), 0);
        rst = 1'b0;

        // R1: first sample per channel passes unchanged
        send(0, 1000, 1'b0, "R1 left first", got);
        chk("R1 left pass", got, 1000);
        send(1, -500, 1'b0, "R1 right first", got);
        chk("R1 right pass", got, -500);

        // R2: idle cycles with junk on the data bus
        idle(24'hABCDEF);
        idle(24'h123456);

        // R3 R4 R5: random interleaved samples, no hold
        for (int i = 0; i < 300; i++) begin
            int ch;
            logic [23:0] r;
            ch = int'($urandom_range(0, 1));
            r  = 24'($urandom);
            send(ch, sx(r), 1'b0, "R3 R4 R5 random", got);
            if ($urandom_range(0, 7) == 0) idle(24'($urandom));
        end

        // R8: constant input decays toward zero
        for (int i = 0; i < 800; i++) send(0, 200000, 1'b0, "R8 dc run", got);
        n_chk++;
        if (got > 2 || got < -2) begin
            n_err++;
            $display("FAIL R8: actual %0d expected |out|<=2", got);
        end

        // R6: hold, estimate stays fixed while input varies
        held = est_m(0);
        for (int i = 0; i < 30; i++) begin
            logic [23:0] r;
            r = 24'($urandom);
            send(0, sx(r), 1'b1, "R6 held", got);
            chk("R6 fixed offset", got, clip_m(sx(r) - held));
            if (i % 5 == 0) send(1, sx(24'($urandom)), 1'b1, "R6 held right", got);
        end
        chk("R6 model estimate unchanged", est_m(0), held);

        // R7: rail estimates, then opposite full scale
        for (int i = 0; i < 1500; i++) send(0, SMINL, 1'b0, "R7 charge left", got);
        send(0, SMAXL, 1'b1, "R7 clip high", got);
        chk("R7 high limit", got, SMAXL);
        for (int i = 0; i < 1500; i++) send(1, SMAXL, 1'b0, "R7 charge right", got);
        send(1, SMINL, 1'b1, "R7 clip low", got);
        chk("R7 low limit", got, SMINL);
        // R5: left estimate survived the right-channel run
        send(0, SMAXL, 1'b1, "R5 left kept", got);
        chk("R5 left still clips", got, SMAXL);

        // Mixed random with hold toggling and idles
        for (int i = 0; i < 400; i++) begin
            send(int'($urandom_range(0, 1)), sx(24'($urandom)),
                 logic'($urandom_range(0, 1)), "R3 R6 mixed", got);
            if ($urandom_range(0, 5) == 0) idle(24'($urandom));
        end

        // R1: reset again clears estimates
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        acc_m[0] = 0;
        acc_m[1] = 0;
        send(1, -12345, 1'b0, "R1 after re-reset", got);
        chk("R1 re-reset pass", got, -12345);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule